// File: doc/BRIEF.md
# Flash Command Chunking Sequencer

This block takes one serial-flash command at a time and turns it into a series of short transactions for an engine underneath. That engine moves at most four data bytes per transaction. A command is made of an opcode, a 24-bit address, a write-data length and a read-data length. The data itself streams through separate byte ports: write bytes are pulled from the caller, and read bytes are pushed back in order.

The sequencer first decodes the opcode. Opcodes with a fixed shape get their byte counts from the decode itself. Bulk reads, page programs and fast reads use the lengths given in the request. The data phase is then sliced into pieces of at most four bytes, and the address advances by the bytes already moved. A program that needs more than one piece is handled step by step. After each piece except the last, the sequencer polls the flash status until the write-in-progress bit drops. It then sends a fresh write-enable before the next piece. A fast read is turned into a plain read, and its timing byte is thrown away. Malformed requests end with an error flag and put nothing on the bus.

Top module: `flash_chunk_seq`

## Requirements
- R1: Each data transaction carries min(remaining, 4) bytes in each direction. Write byte k of a transaction sits in `engTxData[8k+7:8k]`. Received bytes leave on `rdData` in the same little-endian order, one per `rdValid` cycle.
- R2: Each data transaction's `engAddr` equals the command address plus every byte already moved by earlier transactions. Its `engTxCnt` equals 1 + (3 when the opcode carries an address) + its write-byte count.
- R3: After every program (0x02) transaction except the final one, a status read is issued: opcode 0x05, `engTxCnt`=1, `engRxCnt`=1. It is repeated while bit 0 of the returned byte is 1.
- R4: Once a status read returns bit 0 = 0, a write-enable is sent (opcode 0x06, `engTxCnt`=1, `engRxCnt`=0), followed by the next program transaction. No write-enable comes before the first program transaction, and no status read or write-enable follows the last one.
- R5: Fixed-shape opcodes ignore the request lengths and produce one transaction:
  - 0x06, 0x04 and 0xC7: tx 1, rx 0.
  - 0x9F: rx 3.
  - 0x05: rx 1.
  - 0x01: one write byte from the stream, tx 2.
  - 0xAB: 3 address bytes, rx 1.
  - 0xD8: 3 address bytes, tx 4, rx 0.
- R6: A fast read (0x0B) must give a write length of exactly one, for the dummy byte. That byte is popped and dropped. Every transaction then uses opcode 0x03 at the command address.
- R7: The request is rejected with `done`=1, `err`=1 and no `engStart` in three cases: an unknown opcode, a request where both the read length and the effective write length are nonzero, or a fast read with write length 0.
- R8: `done` is a one-cycle pulse. When read and write counts both reach zero after a data transaction, `done` rises with `err`=0, after the last read byte has been delivered.
- R9: `cmdReady` is high only while idle. The cycle after `done`, the block is idle again and accepts a new command.
- R10: If MAX_POLLS (nonzero) consecutive status reads all return busy, the command ends with `err`=1 and no further transaction. MAX_POLLS=0 means no limit.
- R11: At most one engine transaction is in flight: `engStart` never rises between an `engStart` and its `engDone`.
- R12: After reset, `cmdReady`=1, while `done`, `engStart`, `rdValid` and `wrReady` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| cmdValid | input | 1 | Command offered |
| cmdReady | output | 1 | Command accepted this cycle when valid |
| cmdOpcode | input | 8 | Flash opcode |
| cmdAddr | input | ADDR_W | Start address |
| cmdWrLen | input | LEN_W | Bytes to pull from the write stream |
| cmdRdLen | input | LEN_W | Bytes to return on the read stream |
| wrData | input | 8 | Write stream byte |
| wrValid | input | 1 | Write byte available |
| wrReady | output | 1 | Write byte taken when valid |
| rdData | output | 8 | Read stream byte |
| rdValid | output | 1 | Read byte present (no backpressure) |
| engStart | output | 1 | Start one engine transaction |
| engOpcode | output | 8 | Transaction opcode |
| engAddr | output | ADDR_W | Transaction address |
| engTxCnt | output | 4 | Bytes to transmit, opcode included |
| engRxCnt | output | 3 | Bytes to receive |
| engTxData | output | 32 | Transmit data, byte 0 lowest |
| engDone | input | 1 | Transaction finished |
| engRxData | input | 32 | Received data, byte 0 lowest |
| done | output | 1 | Command finished pulse |
| err | output | 1 | Error qualifier of `done` |

## Verification
A wrong remaining-count or address register shows up at the very next `engStart`, as a bad `engAddr`, `engRxCnt` or `engTxCnt`. It also shows up as the wrong number of transactions before `done`. A faulty poll or write-enable decision appears within a few transactions, because the program sequence has the fixed pattern chunk, busy+1 status reads, write-enable. Byte order or index faults change the read stream or the bytes written into the responder's memory on the first affected chunk.

// File: rtl/fcs_pkg.sv
package fcs_pkg;
  localparam int CHUNK_MAX = 4;

  localparam logic [7:0] OP_WREN  = 8'h06;
  localparam logic [7:0] OP_WRDI  = 8'h04;
  localparam logic [7:0] OP_CERASE = 8'hC7;
  localparam logic [7:0] OP_JEDEC = 8'h9F;
  localparam logic [7:0] OP_RDST  = 8'h05;
  localparam logic [7:0] OP_WRST  = 8'h01;
  localparam logic [7:0] OP_OLDID = 8'hAB;
  localparam logic [7:0] OP_SERASE = 8'hD8;
  localparam logic [7:0] OP_READ  = 8'h03;
  localparam logic [7:0] OP_PROG  = 8'h02;
  localparam logic [7:0] OP_FREAD = 8'h0B;

  typedef struct packed {
    logic       known;
    logic       hasAddr;
    logic       fixedShape;
    logic [2:0] fixTx;
    logic [2:0] fixRx;
    logic       isProg;
    logic       isFast;
  } opDecode_t;

  typedef enum logic [1:0] {ENG_DATA, ENG_POLL, ENG_WREN} engKind_t;

  typedef struct packed {
    logic     load;
    logic     setup;
    logic     plan;
    logic     gather;
    logic     capture;
    logic     emit;
    logic     pollClr;
    logic     pollInc;
    engKind_t kind;
  } seqStrobe_t;

  typedef struct packed {
    logic decErr;
    logic isFast;
    logic isProg;
    logic gatherDone;
    logic unloadDone;
    logic lastChunk;
    logic statusBusy;
    logic pollLimit;
  } seqStatus_t;

  function automatic opDecode_t decodeOp(input logic [7:0] opc);
    opDecode_t d;
    d = '0;
    d.known = 1'b1;
    case (opc)
      OP_WREN, OP_WRDI, OP_CERASE: d.fixedShape = 1'b1;
      OP_JEDEC: begin d.fixedShape = 1'b1; d.fixRx = 3'd3; end
      OP_RDST:  begin d.fixedShape = 1'b1; d.fixRx = 3'd1; end
      OP_WRST:  begin d.fixedShape = 1'b1; d.fixTx = 3'd1; end
      OP_OLDID: begin d.fixedShape = 1'b1; d.hasAddr = 1'b1; d.fixRx = 3'd1; end
      OP_SERASE: begin d.fixedShape = 1'b1; d.hasAddr = 1'b1; end
      OP_READ:  d.hasAddr = 1'b1;
      OP_PROG:  begin d.hasAddr = 1'b1; d.isProg = 1'b1; end
      OP_FREAD: begin d.hasAddr = 1'b1; d.isFast = 1'b1; end
      default:  d.known = 1'b0;
    endcase
    return d;
  endfunction
endpackage

// File: rtl/fcs_dp.sv
module fcs_dp
  import fcs_pkg::*;
#(
  parameter int ADDR_W    = 24,
  parameter int LEN_W     = 8,
  parameter int MAX_POLLS = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  seqStrobe_t        stb,
  output seqStatus_t        sts,
  input  logic [7:0]        cmdOpcode,
  input  logic [ADDR_W-1:0] cmdAddr,
  input  logic [LEN_W-1:0]  cmdWrLen,
  input  logic [LEN_W-1:0]  cmdRdLen,
  input  logic [7:0]        wrData,
  input  logic              wrValid,
  output logic [7:0]        rdData,
  output logic [7:0]        engOpcode,
  output logic [ADDR_W-1:0] engAddr,
  output logic [3:0]        engTxCnt,
  output logic [2:0]        engRxCnt,
  output logic [31:0]       engTxData,
  input  logic [31:0]       engRxData
);
  localparam int PW = (MAX_POLLS < 2) ? 1 : $clog2(MAX_POLLS);
  localparam logic [LEN_W-1:0] CHUNK_L = LEN_W'(CHUNK_MAX);

  logic [7:0]        opcReg;
  logic [ADDR_W-1:0] addrReg;
  logic [LEN_W-1:0]  reqWr, reqRd, remWr, remRd;
  logic [2:0]        chTx, chRx, idx;
  logic [31:0]       txBuf, rxBuf;
  logic [PW-1:0]     pollCnt;

  opDecode_t        dec;
  logic [LEN_W-1:0] effWrReq;

  always_comb begin
    dec      = decodeOp(opcReg);
    effWrReq = dec.isFast ? reqWr - LEN_W'(1) : reqWr;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      opcReg <= '0; addrReg <= '0; reqWr <= '0; reqRd <= '0;
      remWr <= '0; remRd <= '0; chTx <= '0; chRx <= '0; idx <= '0;
      txBuf <= '0; rxBuf <= '0; pollCnt <= '0;
    end else begin
      if (stb.load) begin
        opcReg  <= cmdOpcode;
        addrReg <= cmdAddr;
        reqWr   <= cmdWrLen;
        reqRd   <= cmdRdLen;
      end
      if (stb.setup) begin
        remWr <= dec.fixedShape ? LEN_W'(dec.fixTx) : effWrReq;
        remRd <= dec.fixedShape ? LEN_W'(dec.fixRx) : reqRd;
      end
      if (stb.plan) begin
        chTx  <= (remWr >= CHUNK_L) ? 3'(CHUNK_MAX) : remWr[2:0];
        chRx  <= (remRd >= CHUNK_L) ? 3'(CHUNK_MAX) : remRd[2:0];
        idx   <= '0;
        txBuf <= '0;
      end
      if (stb.gather && wrValid && (idx < chTx)) begin
        txBuf[idx[1:0]*8 +: 8] <= wrData;
        idx <= idx + 3'd1;
      end
      if (stb.capture) begin
        rxBuf   <= engRxData;
        idx     <= '0;
        addrReg <= addrReg + ADDR_W'(chTx) + ADDR_W'(chRx);
        remWr   <= remWr - LEN_W'(chTx);
        remRd   <= remRd - LEN_W'(chRx);
      end
      if (stb.emit) idx <= idx + 3'd1;
      if (stb.pollClr) pollCnt <= '0;
      else if (stb.pollInc) pollCnt <= pollCnt + PW'(1);
    end
  end

  always_comb begin
    sts.decErr     = !dec.known || ((reqRd != '0) && (effWrReq != '0))
                     || (dec.isFast && (reqWr == '0));
    sts.isFast     = dec.isFast;
    sts.isProg     = dec.isProg;
    sts.gatherDone = (idx == chTx);
    sts.unloadDone = (idx == chRx);
    sts.lastChunk  = (remWr == '0) && (remRd == '0);
    sts.statusBusy = engRxData[0];
    sts.pollLimit  = (MAX_POLLS != 0) && (int'(pollCnt) == MAX_POLLS - 1);
    rdData         = rxBuf[idx[1:0]*8 +: 8];
    engAddr        = addrReg;
    case (stb.kind)
      ENG_POLL: begin
        engOpcode = OP_RDST; engTxCnt = 4'd1; engRxCnt = 3'd1; engTxData = '0;
      end
      ENG_WREN: begin
        engOpcode = OP_WREN; engTxCnt = 4'd1; engRxCnt = 3'd0; engTxData = '0;
      end
      default: begin
        engOpcode = dec.isFast ? OP_READ : opcReg;
        engTxCnt  = 4'd1 + (dec.hasAddr ? 4'd3 : 4'd0) + 4'(chTx);
        engRxCnt  = chRx;
        engTxData = txBuf;
      end
    endcase
  end
endmodule

// File: rtl/fcs_ctrl.sv
module fcs_ctrl
  import fcs_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       cmdValid,
  output logic       cmdReady,
  input  logic       wrValid,
  output logic       wrReady,
  output logic       rdValid,
  output logic       engStart,
  input  logic       engDone,
  output logic       done,
  output logic       err,
  input  seqStatus_t sts,
  output seqStrobe_t stb
);
  typedef enum logic [3:0] {
    S_IDLE, S_CHECK, S_DUMMY, S_PREP, S_GATHER, S_ISSUE, S_WAIT, S_UNLOAD,
    S_POLL_ISSUE, S_POLL_WAIT, S_WREN_ISSUE, S_WREN_WAIT, S_DONE_OK, S_DONE_ERR
  } state_t;

  state_t state, nxt;

  always_ff @(posedge clk) begin
    if (!rstN) state <= S_IDLE;
    else       state <= nxt;
  end

  always_comb begin
    nxt      = state;
    stb      = '0;
    stb.kind = ENG_DATA;
    cmdReady = (state == S_IDLE);
    wrReady  = (state == S_DUMMY) || ((state == S_GATHER) && !sts.gatherDone);
    rdValid  = (state == S_UNLOAD) && !sts.unloadDone;
    engStart = 1'b0;
    done     = (state == S_DONE_OK) || (state == S_DONE_ERR);
    err      = (state == S_DONE_ERR);
    case (state)
      S_IDLE: if (cmdValid) begin stb.load = 1'b1; nxt = S_CHECK; end
      S_CHECK: begin
        if (sts.decErr) nxt = S_DONE_ERR;
        else begin
          stb.setup = 1'b1;
          nxt = sts.isFast ? S_DUMMY : S_PREP;
        end
      end
      S_DUMMY:  if (wrValid) nxt = S_PREP;
      S_PREP:   begin stb.plan = 1'b1; nxt = S_GATHER; end
      S_GATHER: begin
        stb.gather = !sts.gatherDone;
        if (sts.gatherDone) nxt = S_ISSUE;
      end
      S_ISSUE:  begin engStart = 1'b1; nxt = S_WAIT; end
      S_WAIT:   if (engDone) begin stb.capture = 1'b1; nxt = S_UNLOAD; end
      S_UNLOAD: begin
        if (!sts.unloadDone) stb.emit = 1'b1;
        else if (sts.lastChunk) nxt = S_DONE_OK;
        else if (sts.isProg) begin stb.pollClr = 1'b1; nxt = S_POLL_ISSUE; end
        else nxt = S_PREP;
      end
      S_POLL_ISSUE: begin stb.kind = ENG_POLL; engStart = 1'b1; nxt = S_POLL_WAIT; end
      S_POLL_WAIT: begin
        stb.kind = ENG_POLL;
        if (engDone) begin
          if (!sts.statusBusy) nxt = S_WREN_ISSUE;
          else if (sts.pollLimit) nxt = S_DONE_ERR;
          else begin stb.pollInc = 1'b1; nxt = S_POLL_ISSUE; end
        end
      end
      S_WREN_ISSUE: begin stb.kind = ENG_WREN; engStart = 1'b1; nxt = S_WREN_WAIT; end
      S_WREN_WAIT: begin
        stb.kind = ENG_WREN;
        if (engDone) nxt = S_PREP;
      end
      S_DONE_OK, S_DONE_ERR: nxt = S_IDLE;
      default: nxt = S_IDLE;
    endcase
  end
endmodule

// File: rtl/flash_chunk_seq.sv
module flash_chunk_seq
  import fcs_pkg::*;
#(
  parameter int ADDR_W    = 24,
  parameter int LEN_W     = 8,
  parameter int MAX_POLLS = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              cmdValid,
  output logic              cmdReady,
  input  logic [7:0]        cmdOpcode,
  input  logic [ADDR_W-1:0] cmdAddr,
  input  logic [LEN_W-1:0]  cmdWrLen,
  input  logic [LEN_W-1:0]  cmdRdLen,
  input  logic [7:0]        wrData,
  input  logic              wrValid,
  output logic              wrReady,
  output logic [7:0]        rdData,
  output logic              rdValid,
  output logic              engStart,
  output logic [7:0]        engOpcode,
  output logic [ADDR_W-1:0] engAddr,
  output logic [3:0]        engTxCnt,
  output logic [2:0]        engRxCnt,
  output logic [31:0]       engTxData,
  input  logic              engDone,
  input  logic [31:0]       engRxData,
  output logic              done,
  output logic              err
);
  seqStrobe_t stb;
  seqStatus_t sts;

  fcs_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .cmdValid(cmdValid), .cmdReady(cmdReady),
    .wrValid(wrValid), .wrReady(wrReady), .rdValid(rdValid),
    .engStart(engStart), .engDone(engDone), .done(done), .err(err),
    .sts(sts), .stb(stb)
  );

  fcs_dp #(.ADDR_W(ADDR_W), .LEN_W(LEN_W), .MAX_POLLS(MAX_POLLS)) u_dp (
    .clk(clk), .rstN(rstN), .stb(stb), .sts(sts),
    .cmdOpcode(cmdOpcode), .cmdAddr(cmdAddr), .cmdWrLen(cmdWrLen),
    .cmdRdLen(cmdRdLen), .wrData(wrData), .wrValid(wrValid), .rdData(rdData),
    .engOpcode(engOpcode), .engAddr(engAddr), .engTxCnt(engTxCnt),
    .engRxCnt(engRxCnt), .engTxData(engTxData), .engRxData(engRxData)
  );
endmodule

// File: rtl/flash_chunk_seq_chk.sv
module flash_chunk_seq_chk (
  input logic       clk,
  input logic       rstN,
  input logic       cmdReady,
  input logic       engStart,
  input logic [7:0] engOpcode,
  input logic [3:0] engTxCnt,
  input logic [2:0] engRxCnt,
  input logic       engDone,
  input logic       done,
  input logic       err
);
  logic pend;

  always_ff @(posedge clk) begin
    if (!rstN)        pend <= 1'b0;
    else if (engStart) pend <= 1'b1;
    else if (engDone)  pend <= 1'b0;
  end

  AST_ONE_IN_FLIGHT: assert property (@(posedge clk) disable iff (!rstN)
    engStart |-> !pend); // R11
  AST_CHUNK_BOUND: assert property (@(posedge clk) disable iff (!rstN)
    engStart |-> (engRxCnt <= 3'd4) && (engTxCnt <= 4'd8)); // R1
  AST_POLL_SHAPE: assert property (@(posedge clk) disable iff (!rstN)
    (engStart && engOpcode == 8'h05) |-> (engTxCnt == 4'd1) && (engRxCnt == 3'd1)); // R3
  AST_WREN_SHAPE: assert property (@(posedge clk) disable iff (!rstN)
    (engStart && engOpcode == 8'h06) |-> (engTxCnt == 4'd1) && (engRxCnt == 3'd0)); // R4
  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done); // R8
  AST_IDLE_AFTER_DONE: assert property (@(posedge clk) disable iff (!rstN)
    done |=> cmdReady); // R9
  AST_READY_QUIET: assert property (@(posedge clk) disable iff (!rstN)
    cmdReady |-> !pend && !engStart); // R9
  AST_ERR_QUAL: assert property (@(posedge clk) disable iff (!rstN)
    err |-> done); // R7
endmodule

bind flash_chunk_seq flash_chunk_seq_chk u_chk (
  .clk(clk), .rstN(rstN), .cmdReady(cmdReady), .engStart(engStart),
  .engOpcode(engOpcode), .engTxCnt(engTxCnt), .engRxCnt(engRxCnt),
  .engDone(engDone), .done(done), .err(err)
);

// File: tb/flash_chunk_seq_tb.sv
`timescale 1ns/1ps
module flash_chunk_seq_tb;
  localparam int ADDR_W = 24;
  localparam int LEN_W  = 8;
  localparam int POLLS  = 4;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  always #2 clk = ~clk;

  logic              cmdValid = 1'b0, cmdReady;
  logic [7:0]        cmdOpcode = '0;
  logic [ADDR_W-1:0] cmdAddr = '0;
  logic [LEN_W-1:0]  cmdWrLen = '0, cmdRdLen = '0;
  logic [7:0]        wrData;
  logic              wrValid = 1'b0, wrReady;
  logic [7:0]        rdData;
  logic              rdValid;
  logic              engStart;
  logic [7:0]        engOpcode;
  logic [ADDR_W-1:0] engAddr;
  logic [3:0]        engTxCnt;
  logic [2:0]        engRxCnt;
  logic [31:0]       engTxData;
  logic              engDone = 1'b0;
  logic [31:0]       engRxData = '0;
  logic              done, err;

  flash_chunk_seq #(.ADDR_W(ADDR_W), .LEN_W(LEN_W), .MAX_POLLS(POLLS)) u_dut (.*);

  int checks = 0, fails = 0;
  int wrIdx = 0, rdCnt = 0, logN = 0, busyLeft = 0, busySet = 0;
  logic [7:0]  rdBuf [1024];
  logic [7:0]  mem [256];
  logic [7:0]  logOpc [512];
  logic [23:0] logAddr [512];
  logic [3:0]  logTx [512];
  logic [2:0]  logRx [512];
  logic [31:0] logData [512];
  logic        pend = 1'b0;
  int          dly = 0;
  logic [31:0] rxNext = '0;

  function automatic logic [7:0] pat(input int i); return 8'((i * 13 + 5) & 255); endfunction
  function automatic logic [7:0] fmem(input int a); return 8'((a * 7 + 3) & 255); endfunction

  assign wrData = pat(wrIdx);

  always @(posedge clk) begin
    if (wrValid && wrReady) wrIdx <= wrIdx + 1;
    if (rdValid) begin rdBuf[rdCnt % 1024] <= rdData; rdCnt <= rdCnt + 1; end
  end

  // simple flash responder
  always @(posedge clk) begin
    engDone <= 1'b0;
    if (engStart) begin
      logOpc[logN % 512]  <= engOpcode;
      logAddr[logN % 512] <= engAddr;
      logTx[logN % 512]   <= engTxCnt;
      logRx[logN % 512]   <= engRxCnt;
      logData[logN % 512] <= engTxData;
      logN <= logN + 1;
      pend <= 1'b1;
      dly  <= 2;
      case (engOpcode)
        8'h03: for (int i = 0; i < 4; i++) rxNext[i*8 +: 8] <= fmem(int'(engAddr) + i);
        8'h9F: rxNext <= 32'h00A3A2A1;
        8'hAB: rxNext <= 32'h0000005C;
        8'h05: begin
          rxNext <= (busyLeft > 0) ? 32'd1 : 32'd0;
          if (busyLeft > 0) busyLeft <= busyLeft - 1;
        end
        8'h02: begin
          for (int i = 0; i < int'(engTxCnt) - 4; i++)
            mem[(int'(engAddr) + i) & 255] <= engTxData[i*8 +: 8];
          busyLeft <= busySet;
          rxNext <= '0;
        end
        default: rxNext <= '0;
      endcase
    end else if (pend) begin
      if (dly == 1) begin engDone <= 1'b1; engRxData <= rxNext; pend <= 1'b0; end
      else dly <= dly - 1;
    end
  end

  task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  int logBase, rdBase, wrBase, nLog;
  logic lastErr;

  task automatic runCmd(input logic [7:0] opc, input int addr, input int wl, input int rl);
    logBase = logN; rdBase = rdCnt; wrBase = wrIdx;
    @(negedge clk);
    cmdValid = 1'b1; cmdOpcode = opc; cmdAddr = ADDR_W'(addr);
    cmdWrLen = LEN_W'(wl); cmdRdLen = LEN_W'(rl);
    while (!cmdReady) @(negedge clk);
    @(negedge clk);
    cmdValid = 1'b0;
    while (!done) @(negedge clk);
    lastErr = err;
    @(negedge clk);
    chk(cmdReady == 1'b1, "R9", "ready after done", int'(cmdReady), 1);
    nLog = logN - logBase;
  endtask

  task automatic mainSeq();
    repeat (3) @(negedge clk);
    chk(cmdReady == 1'b1, "R12", "reset cmdReady", int'(cmdReady), 1);
    chk(done == 1'b0 && engStart == 1'b0, "R12", "reset done/engStart", int'(done | engStart), 0);
    chk(rdValid == 1'b0 && wrReady == 1'b0, "R12", "reset streams", int'(rdValid | wrReady), 0);
    rstN = 1'b1;
    wrValid = 1'b1;

    // read sweep: R1 R2 R8
    for (int a = 0; a < 2; a++) begin
      for (int rl = 0; rl < 10; rl++) begin
        int base, n;
        base = (a == 0) ? 32'h10 : 32'h01FE;
        n = (rl == 0) ? 1 : (rl + 3) / 4;
        runCmd(8'h03, base, 0, rl);
        chk(lastErr == 1'b0, "R8", "read err", int'(lastErr), 0);
        chk(nLog == n, "R1", "read transaction count", nLog, n);
        for (int k = 0; k < n; k++) begin
          int e; int j;
          j = (logBase + k) % 512;
          e = (rl - 4 * k > 4) ? 4 : ((rl - 4 * k < 0) ? 0 : rl - 4 * k);
          chk(int'(logRx[j]) == e, "R1", "read rx count", int'(logRx[j]), e);
          chk(int'(logAddr[j]) == base + 4 * k, "R2", "read addr", int'(logAddr[j]), base + 4 * k);
          chk(int'(logTx[j]) == 4, "R2", "read tx count", int'(logTx[j]), 4);
        end
        chk(rdCnt - rdBase == rl, "R1", "read bytes out", rdCnt - rdBase, rl);
        for (int i = 0; i < rl; i++)
          chk(rdBuf[(rdBase + i) % 1024] == fmem(base + i), "R1", "read byte",
              int'(rdBuf[(rdBase + i) % 1024]), int'(fmem(base + i)));
      end
    end

    // program sweep: R1 R2 R3 R4
    for (int b = 0; b < 3; b++) begin
      for (int wl = 0; wl < 10; wl++) begin
        int n, step;
        busySet = b;
        n = (wl == 0) ? 1 : (wl + 3) / 4;
        step = b + 3;
        runCmd(8'h02, 32'h80, wl, 0);
        chk(lastErr == 1'b0, "R8", "prog err", int'(lastErr), 0);
        chk(nLog == n + (n - 1) * (b + 2), "R3", "prog transaction count", nLog, n + (n - 1) * (b + 2));
        chk(wrIdx - wrBase == wl, "R1", "prog bytes taken", wrIdx - wrBase, wl);
        for (int k = 0; k < n; k++) begin
          int j, e;
          j = (logBase + k * step) % 512;
          e = (wl - 4 * k > 4) ? 4 : wl - 4 * k;
          if (e < 0) e = 0;
          chk(logOpc[j] == 8'h02, "R4", "chunk opcode (no leading wren)", int'(logOpc[j]), 2);
          chk(int'(logAddr[j]) == 32'h80 + 4 * k, "R2", "prog addr", int'(logAddr[j]), 32'h80 + 4 * k);
          chk(int'(logTx[j]) == 4 + e, "R2", "prog tx count", int'(logTx[j]), 4 + e);
          if (k < n - 1) begin
            for (int p = 1; p <= b + 1; p++)
              chk(logOpc[(j + p) % 512] == 8'h05 && logRx[(j + p) % 512] == 3'd1, "R3", "status poll",
                  int'(logOpc[(j + p) % 512]), 5);
            chk(logOpc[(j + b + 2) % 512] == 8'h06 && logTx[(j + b + 2) % 512] == 4'd1, "R4", "write enable",
                int'(logOpc[(j + b + 2) % 512]), 6);
          end
        end
        for (int i = 0; i < wl; i++)
          chk(mem[(32'h80 + i) & 255] == pat(wrBase + i), "R1", "programmed byte",
              int'(mem[(32'h80 + i) & 255]), int'(pat(wrBase + i)));
      end
    end
    busySet = 0;

    // fast read: R6
    runCmd(8'h0B, 32'h33, 1, 6);
    chk(lastErr == 1'b0, "R6", "fast err", int'(lastErr), 0);
    chk(wrIdx - wrBase == 1, "R6", "dummy consumed", wrIdx - wrBase, 1);
    chk(nLog == 2, "R6", "fast count", nLog, 2);
    chk(logOpc[logBase % 512] == 8'h03 && logOpc[(logBase + 1) % 512] == 8'h03, "R6", "fast rewritten",
        int'(logOpc[logBase % 512]), 3);
    chk(int'(logAddr[logBase % 512]) == 32'h33, "R6", "fast addr", int'(logAddr[logBase % 512]), 32'h33);
    for (int i = 0; i < 6; i++)
      chk(rdBuf[(rdBase + i) % 1024] == fmem(32'h33 + i), "R6", "fast byte",
          int'(rdBuf[(rdBase + i) % 1024]), int'(fmem(32'h33 + i)));

    // fixed shapes: R5
    runCmd(8'h9F, 0, 0, 0);
    chk(nLog == 1 && logTx[logBase % 512] == 4'd1 && logRx[logBase % 512] == 3'd3, "R5", "jedec shape",
        int'(logRx[logBase % 512]), 3);
    chk(rdCnt - rdBase == 3 && rdBuf[rdBase % 1024] == 8'hA1 && rdBuf[(rdBase + 2) % 1024] == 8'hA3,
        "R5", "jedec bytes", int'(rdBuf[rdBase % 1024]), 32'hA1);
    runCmd(8'hAB, 32'h123456, 0, 9);
    chk(nLog == 1 && logTx[logBase % 512] == 4'd4 && logRx[logBase % 512] == 3'd1, "R5", "legacy id shape",
        int'(logTx[logBase % 512]), 4);
    chk(rdCnt - rdBase == 1 && rdBuf[rdBase % 1024] == 8'h5C, "R5", "legacy id byte",
        int'(rdBuf[rdBase % 1024]), 32'h5C);
    runCmd(8'h01, 0, 1, 0);
    chk(nLog == 1 && logTx[logBase % 512] == 4'd2 && logData[logBase % 512][7:0] == pat(wrBase),
        "R5", "status write", int'(logData[logBase % 512][7:0]), int'(pat(wrBase)));
    runCmd(8'hC7, 0, 0, 0);
    chk(nLog == 1 && logTx[logBase % 512] == 4'd1 && logRx[logBase % 512] == 3'd0, "R5", "chip erase",
        int'(logTx[logBase % 512]), 1);
    runCmd(8'hD8, 32'h4000, 0, 0);
    chk(nLog == 1 && logTx[logBase % 512] == 4'd4 && int'(logAddr[logBase % 512]) == 32'h4000,
        "R5", "sector erase", int'(logTx[logBase % 512]), 4);
    runCmd(8'h05, 0, 0, 0);
    chk(nLog == 1 && logRx[logBase % 512] == 3'd1 && rdCnt - rdBase == 1, "R5", "status read",
        rdCnt - rdBase, 1);

    // rejections: R7
    runCmd(8'h77, 0, 0, 4);
    chk(lastErr == 1'b1 && nLog == 0, "R7", "unknown opcode", nLog, 0);
    runCmd(8'h03, 0, 2, 3);
    chk(lastErr == 1'b1 && nLog == 0, "R7", "mixed request", nLog, 0);
    runCmd(8'h0B, 0, 0, 4);
    chk(lastErr == 1'b1 && nLog == 0, "R7", "fast without dummy", nLog, 0);
    runCmd(8'h9F, 0, 1, 1);
    chk(lastErr == 1'b1 && nLog == 0, "R7", "mixed fixed", nLog, 0);

    // poll limit: R10
    busySet = 10;
    runCmd(8'h02, 32'h90, 8, 0);
    chk(lastErr == 1'b1, "R10", "poll limit err", int'(lastErr), 1);
    chk(nLog == 1 + POLLS, "R10", "poll limit traffic", nLog, 1 + POLLS);
    busySet = 0;

    // recovery: R9 R11
    runCmd(8'h03, 32'h20, 0, 5);
    chk(lastErr == 1'b0 && nLog == 2, "R11", "next command runs", nLog, 2);
  endtask

  initial begin
    fork
      mainSeq();
      begin
        repeat (150000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
      end
    join_any
    disable fork;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule